// File: doc/BRIEF.md
# Linked-Descriptor Chain Walker

This block follows a chain of 32-byte transfer descriptors stored in memory and hands each one to an external data mover. Software loads the head address into the next-pointer register, then pulses the start control. The walker first reads the descriptor's top word, which holds the control byte. If the hardware-owned flag (bit 7 of that byte) is set, it reads the source address, destination address, link pointer and length words. It then launches the mover with those values. When the mover reports completion, the walker writes the top word back with the bytes moved, the mover's status byte and the control byte. It advances the next-pointer register to the link and carries on.

A descriptor whose owned flag is clear ends the walk. Without polling, the walker drops to idle and pulses chain-complete. With polling enabled, it waits a programmable number of clocks and reads the same descriptor again, so software can append work to a live chain. A keep-owned control leaves the owned flag set in the written-back byte. A halt-on-error control stops the walk after a descriptor whose status bit 0 is set. A soft reset abandons whatever is in flight.

The controller has ten named states.
- `ST_IDLE`: leaves on start to `ST_RD_CTL`.
- `ST_RD_CTL`: on the memory answer it moves to `ST_RD_SRC` if the descriptor is owned. If it is not owned, it moves to `ST_POLL_WAIT` when polling is enabled, otherwise to `ST_IDLE`.
- `ST_RD_SRC`, `ST_RD_DST`, `ST_RD_NXT`, `ST_RD_LEN`: each advances to the next state when its read is answered. `ST_RD_LEN` leads to `ST_LAUNCH`.
- `ST_LAUNCH`: always moves to `ST_MOVE` after one cycle.
- `ST_MOVE`: moves to `ST_WR_BACK` when the mover reports done.
- `ST_WR_BACK`: when the write is answered, it moves to `ST_IDLE` on an error halt, otherwise back to `ST_RD_CTL`.
- `ST_POLL_WAIT`: returns to `ST_RD_CTL` when the poll timer expires.
- Any state: soft reset forces `ST_IDLE`.

Top module: `desc_walker`

## Requirements
- R1: After reset, `busy`, `mem_req`, `mv_start`, `desc_done` and `chain_done` are low and `nxt_ptr` is 0.
- R2: A `ctl_go` pulse while idle sets `busy`. In the following cycle the walker issues a read (`mem_we`=0) at `nxt_ptr`+28.
- R3: The descriptor layout is fixed. The source address is the word at +0, the destination at +8, the link at +16, and the length in bits 15:0 of the word at +24. The control byte is bits 31:24 of the word at +28. Control bits 0, 1 and 2 drive `mv_eop`, `mv_src_fixed` and `mv_dst_fixed`, which are valid with the one-cycle `mv_start` pulse.
- R4: After `mv_done`, the walker makes exactly one write to +28. The written word is {control byte, `mv_status`, `mv_xferred`}, from bit 31 down to bit 0.
- R5: With `ctl_keep_own`=0, bit 7 of the written-back control byte is 0. With `ctl_keep_own`=1, the byte is written back unchanged.
- R6: When a write-back is answered, `nxt_ptr` takes the link value and the next read is at link+28.
- R7: An unowned descriptor with polling off ends the walk. `busy` falls, `chain_done` pulses once, no mover start occurs, and `nxt_ptr` keeps that descriptor's address.
- R8: With `ctl_poll_en`=1, an unowned descriptor's +28 word is read again after a wait of `ctl_poll_gap` clocks. With memory answering one cycle after each request, successive answered requests are `ctl_poll_gap`+3 cycles apart.
- R9: With `ctl_halt_on_err`=1, a write-back whose `mv_status` bit 0 is set returns the walker to idle. `nxt_ptr` holds the link, and no further descriptor is read and no `chain_done` occurs.
- R10: `ctl_soft_rst` makes the walker idle on the next cycle. A later `mv_done` causes no write-back.
- R11: `mem_req` stays high with a stable `mem_addr` until `mem_ack`.
- R12: `desc_done` pulses for one cycle per answered write-back and never together with `chain_done`.
- R13: `ptr_wr_en` loads `nxt_ptr` only while idle. While busy it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_go | input | 1 | Start pulse |
| ctl_soft_rst | input | 1 | Abandon the walk and go idle |
| ctl_keep_own | input | 1 | Keep owned flag set on write-back |
| ctl_halt_on_err | input | 1 | Halt after an errored descriptor |
| ctl_poll_en | input | 1 | Re-read unowned descriptors |
| ctl_poll_gap | input | GAP_W | Poll wait in clocks |
| ptr_wr_en | input | 1 | Load next-pointer register |
| ptr_wr_data | input | ADDR_W | Value to load |
| nxt_ptr | output | ADDR_W | Current/next descriptor address |
| busy | output | 1 | Walker active |
| desc_done | output | 1 | Write-back answered pulse |
| chain_done | output | 1 | Chain ended on unowned descriptor |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request answered |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mv_start | output | 1 | Mover launch pulse |
| mv_src | output | ADDR_W | Source address |
| mv_dst | output | ADDR_W | Destination address |
| mv_len | output | 16 | Byte count |
| mv_eop | output | 1 | End-of-packet flag |
| mv_src_fixed | output | 1 | Fixed source address |
| mv_dst_fixed | output | 1 | Fixed destination address |
| mv_done | input | 1 | Mover finished |
| mv_xferred | input | 16 | Bytes moved |
| mv_status | input | 8 | Mover status byte |

## Verification
The bench runs a chain ending on an unowned descriptor. A walker that ignored the owned flag would launch the mover on garbage, and one that lost the link would stop early or leave `nxt_ptr` stale. It measures the spacing of poll re-reads, which an off-by-one timer would shift. It then hands ownership over mid-poll to confirm the walker picks the descriptor up. The error-halt and soft-reset cases target a walker that runs past an errored descriptor, or that writes back a transfer abandoned in `ST_MOVE` after its late `mv_done`. A pointer write while busy catches a register that would redirect a live walk.

// File: rtl/dwalk_pkg.sv
package dwalk_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_RD_CTL, ST_RD_SRC, ST_RD_DST, ST_RD_NXT,
        ST_RD_LEN, ST_LAUNCH, ST_MOVE, ST_WR_BACK, ST_POLL_WAIT
    } dwalk_state_t;

    localparam int OFS_SRC  = 0;
    localparam int OFS_DST  = 8;
    localparam int OFS_LINK = 16;
    localparam int OFS_LEN  = 24;
    localparam int OFS_TOP  = 28;

    localparam int CB_EOP   = 0;
    localparam int CB_SFIX  = 1;
    localparam int CB_DFIX  = 2;
    localparam int CB_OWNED = 7;

    function automatic int word_offset(dwalk_state_t s);
        case (s)
            ST_RD_SRC: return OFS_SRC;
            ST_RD_DST: return OFS_DST;
            ST_RD_NXT: return OFS_LINK;
            ST_RD_LEN: return OFS_LEN;
            default:   return OFS_TOP;
        endcase
    endfunction
endpackage

// File: rtl/dwalk_poll_timer.sv
module dwalk_poll_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    output logic             expired
);
    logic [GAP_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dwalk_desc_regs.sv
module dwalk_desc_regs
    import dwalk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dwalk_state_t      st,
    input  logic              cap,
    input  logic [31:0]       rdata,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [ADDR_W-1:0] link_q,
    output logic [15:0]       len_q,
    output logic [7:0]        ctl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            link_q <= '0;
            len_q  <= '0;
            ctl_q  <= '0;
        end else if (cap) begin
            unique case (st)
                ST_RD_CTL: ctl_q  <= rdata[31:24];
                ST_RD_SRC: src_q  <= rdata[ADDR_W-1:0];
                ST_RD_DST: dst_q  <= rdata[ADDR_W-1:0];
                ST_RD_NXT: link_q <= rdata[ADDR_W-1:0];
                ST_RD_LEN: len_q  <= rdata[15:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/desc_walker.sv
module desc_walker
    import dwalk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_go,
    input  logic              ctl_soft_rst,
    input  logic              ctl_keep_own,
    input  logic              ctl_halt_on_err,
    input  logic              ctl_poll_en,
    input  logic [GAP_W-1:0]  ctl_poll_gap,
    input  logic              ptr_wr_en,
    input  logic [ADDR_W-1:0] ptr_wr_data,
    output logic [ADDR_W-1:0] nxt_ptr,
    output logic              busy,
    output logic              desc_done,
    output logic              chain_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              mv_start,
    output logic [ADDR_W-1:0] mv_src,
    output logic [ADDR_W-1:0] mv_dst,
    output logic [15:0]       mv_len,
    output logic              mv_eop,
    output logic              mv_src_fixed,
    output logic              mv_dst_fixed,
    input  logic              mv_done,
    input  logic [15:0]       mv_xferred,
    input  logic [7:0]        mv_status
);
    dwalk_state_t st_q, st_d;

    logic              owned;
    logic              rd_state;
    logic              cap;
    logic              tmr_load;
    logic              tmr_expired;
    logic [ADDR_W-1:0] link_q;
    logic [7:0]        ctl_q;
    logic [7:0]        ctl_out;
    logic [15:0]       xf_q;
    logic [7:0]        stat_q;

    assign owned    = mem_rdata[24 + CB_OWNED];
    assign rd_state = (st_q == ST_RD_CTL) || (st_q == ST_RD_SRC) || (st_q == ST_RD_DST)
                   || (st_q == ST_RD_NXT) || (st_q == ST_RD_LEN);
    assign cap      = rd_state && mem_ack && !ctl_soft_rst;
    assign tmr_load = (st_q == ST_RD_CTL) && mem_ack && !owned;

    dwalk_desc_regs #(.ADDR_W(ADDR_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .st(st_q), .cap(cap), .rdata(mem_rdata),
        .src_q(mv_src), .dst_q(mv_dst), .link_q(link_q), .len_q(mv_len), .ctl_q(ctl_q)
    );

    dwalk_poll_timer #(.GAP_W(GAP_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(ctl_poll_gap),
        .expired(tmr_expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:      if (ctl_go) st_d = ST_RD_CTL;
            ST_RD_CTL:    if (mem_ack) st_d = owned ? ST_RD_SRC
                                             : (ctl_poll_en ? ST_POLL_WAIT : ST_IDLE);
            ST_RD_SRC:    if (mem_ack) st_d = ST_RD_DST;
            ST_RD_DST:    if (mem_ack) st_d = ST_RD_NXT;
            ST_RD_NXT:    if (mem_ack) st_d = ST_RD_LEN;
            ST_RD_LEN:    if (mem_ack) st_d = ST_LAUNCH;
            ST_LAUNCH:    st_d = ST_MOVE;
            ST_MOVE:      if (mv_done) st_d = ST_WR_BACK;
            ST_WR_BACK:   if (mem_ack) st_d = (ctl_halt_on_err && stat_q[0]) ? ST_IDLE
                                                                              : ST_RD_CTL;
            ST_POLL_WAIT: if (tmr_expired) st_d = ST_RD_CTL;
            default:      st_d = ST_IDLE;
        endcase
        if (ctl_soft_rst) st_d = ST_IDLE;
    end

    // datapath registers: pointer and mover result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_ptr <= '0;
            xf_q    <= '0;
            stat_q  <= '0;
        end else begin
            if (st_q == ST_IDLE && ptr_wr_en)
                nxt_ptr <= ptr_wr_data;
            else if (desc_done)
                nxt_ptr <= link_q;
            if (st_q == ST_MOVE && mv_done) begin
                xf_q   <= mv_xferred;
                stat_q <= mv_status;
            end
        end
    end

    assign ctl_out = ctl_keep_own ? ctl_q : {1'b0, ctl_q[6:0]};

    // outputs
    always_comb begin
        busy         = (st_q != ST_IDLE);
        mem_req      = rd_state || (st_q == ST_WR_BACK);
        mem_we       = (st_q == ST_WR_BACK);
        mem_addr     = nxt_ptr + ADDR_W'(word_offset(st_q));
        mem_wdata    = {ctl_out, stat_q, xf_q};
        mv_start     = (st_q == ST_LAUNCH);
        mv_eop       = ctl_q[CB_EOP];
        mv_src_fixed = ctl_q[CB_SFIX];
        mv_dst_fixed = ctl_q[CB_DFIX];
        desc_done    = (st_q == ST_WR_BACK) && mem_ack && !ctl_soft_rst;
        chain_done   = (st_q == ST_RD_CTL) && mem_ack && !owned && !ctl_poll_en
                    && !ctl_soft_rst;
    end
endmodule

// File: rtl/dwalk_chk.sv
module dwalk_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_soft_rst,
    input logic              ctl_keep_own,
    input logic              busy,
    input logic              desc_done,
    input logic              chain_done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack,
    input logic              mv_start
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !ctl_soft_rst |=> mem_req && $stable(mem_addr));
    // R5
    own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && !ctl_keep_own |-> !mem_wdata[31]);
    // R10
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_soft_rst |=> !busy);
    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start |=> !mv_start);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !mv_start);
    // R12
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_done && chain_done));
endmodule

bind desc_walker dwalk_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .ctl_soft_rst(ctl_soft_rst), .ctl_keep_own(ctl_keep_own),
    .busy(busy), .desc_done(desc_done), .chain_done(chain_done), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mv_start(mv_start)
);

// File: tb/test_desc_walker.sv
`timescale 1ns/1ps
module test_desc_walker;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        ctl_go = 0, ctl_soft_rst = 0, ctl_keep_own = 0, ctl_halt_on_err = 0;
    logic        ctl_poll_en = 0;
    logic [7:0]  ctl_poll_gap = 0;
    logic        ptr_wr_en = 0;
    logic [31:0] ptr_wr_data = 0;
    logic [31:0] nxt_ptr;
    logic        busy, desc_done, chain_done;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mv_start, mv_eop, mv_src_fixed, mv_dst_fixed, mv_done;
    logic [31:0] mv_src, mv_dst;
    logic [15:0] mv_len, mv_xferred;
    logic [7:0]  mv_status;

    always #10 clk = ~clk;

    desc_walker i_desc_walker (.*);

    int checks = 0, errors = 0;
    bit finished = 0;

    // memory model: answers one cycle after request
    logic [31:0] mem [0:63];
    logic        bk_we = 0;
    logic [5:0]  bk_idx = 0;
    logic [31:0] bk_data = 0;
    int cyc = 0, wr_cnt = 0, t_last = 0, t_prev = 0;
    initial mem_ack = 0;
    initial mem_rdata = 0;
    initial for (int i = 0; i < 64; i++) mem[i] = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (bk_we) mem[bk_idx] <= bk_data;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1;
            if (mem_we) begin
                mem[mem_addr[7:2]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr[7:2]];
                if (mem_addr[4:0] == 5'h1C) begin
                    t_prev <= t_last;
                    t_last <= cyc;
                end
            end
        end else mem_ack <= 0;
    end

    // mover model
    int mv_cnt = 0, mv_delay = 3, mv_timer = 0;
    logic [7:0]  mv_stat_cfg = 8'h80;
    logic [31:0] cap_src [0:7];
    logic [31:0] cap_dst [0:7];
    logic [15:0] cap_len [0:7];
    logic [2:0]  cap_flg [0:7];
    initial begin mv_done = 0; mv_xferred = 0; end
    assign mv_status = mv_stat_cfg;
    always @(posedge clk) begin
        mv_done <= 0;
        if (mv_start) begin
            cap_src[mv_cnt[2:0]] <= mv_src;
            cap_dst[mv_cnt[2:0]] <= mv_dst;
            cap_len[mv_cnt[2:0]] <= mv_len;
            cap_flg[mv_cnt[2:0]] <= {mv_dst_fixed, mv_src_fixed, mv_eop};
            mv_xferred <= mv_len;
            mv_cnt <= mv_cnt + 1;
            mv_timer <= mv_delay;
        end else if (mv_timer > 1) mv_timer <= mv_timer - 1;
        else if (mv_timer == 1) begin
            mv_done <= 1;
            mv_timer <= 0;
        end
    end

    int chain_cnt = 0, dd_cnt = 0;
    always @(posedge clk) begin
        if (chain_done) chain_cnt <= chain_cnt + 1;
        if (desc_done)  dd_cnt <= dd_cnt + 1;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bk_write(logic [31:0] addr, logic [31:0] data);
        @(negedge clk);
        bk_we = 1; bk_idx = addr[7:2]; bk_data = data;
        @(negedge clk);
        bk_we = 0;
    endtask

    task automatic put_desc(logic [31:0] base, logic [31:0] src, logic [31:0] dst,
                            logic [31:0] link, logic [15:0] len, logic [7:0] ctl);
        bk_write(base + 0,  src);
        bk_write(base + 8,  dst);
        bk_write(base + 16, link);
        bk_write(base + 24, {16'h0404, len});
        bk_write(base + 28, {ctl, 24'h0});
    endtask

    task automatic load_ptr(logic [31:0] v);
        @(negedge clk); ptr_wr_en = 1; ptr_wr_data = v;
        @(negedge clk); ptr_wr_en = 0;
    endtask

    task automatic pulse_go();
        @(negedge clk); ctl_go = 1;
        @(negedge clk); ctl_go = 0;
    endtask

    task automatic wait_idle(string req);
        int n = 0;
        while (busy && n < 3000) begin @(negedge clk); n++; end
        check(req, {31'b0, busy}, 32'h0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 busy", {31'b0, busy}, 0);
        check("R1 mem_req", {31'b0, mem_req}, 0);
        check("R1 outputs", {29'b0, mv_start, desc_done, chain_done}, 0);
        check("R1 nxt_ptr", nxt_ptr, 0);
    endtask

    task automatic t_chain();
        put_desc(32'h00, 32'h1000, 32'h2000, 32'h20, 16'd64, 8'h81);
        put_desc(32'h20, 32'h3000, 32'h4000, 32'h40, 16'd5,  8'h86);
        put_desc(32'h40, 32'h5000, 32'h6000, 32'h60, 16'd9,  8'h00);
        load_ptr(32'h0);
        @(negedge clk); ctl_go = 1;
        @(negedge clk); ctl_go = 0;
        check("R2 busy", {31'b0, busy}, 1);
        check("R2 first read", {mem_req, mem_we, mem_addr[29:0]}, {2'b10, 30'h1C});
        wait_idle("R7 idle");
        check("R3 mover count", mv_cnt, 2);
        check("R3 src A", cap_src[0], 32'h1000);
        check("R3 dst A", cap_dst[0], 32'h2000);
        check("R3 len A", {16'h0, cap_len[0]}, 64);
        check("R3 flags A", {29'b0, cap_flg[0]}, 3'b001);
        check("R3 src B", cap_src[1], 32'h3000);
        check("R3 flags B", {29'b0, cap_flg[1]}, 3'b110);
        check("R4 R5 wb A", mem[7], {8'h01, 8'h80, 16'd64});
        check("R4 R5 wb B", mem[15], {8'h06, 8'h80, 16'd5});
        check("R4 write count", wr_cnt, 2);
        check("R6 R7 nxt_ptr", nxt_ptr, 32'h40);
        check("R7 chain_done", chain_cnt, 1);
        check("R7 C untouched", mem[23], 32'h0);
        check("R12 desc_done", dd_cnt, 2);
    endtask

    task automatic t_keep_own();
        put_desc(32'h60, 32'h7000, 32'h7100, 32'h40, 16'd12, 8'h81);
        ctl_keep_own = 1;
        load_ptr(32'h60);
        pulse_go();
        wait_idle("R5 idle");
        check("R5 keep owned", mem[31], {8'h81, 8'h80, 16'd12});
        ctl_keep_own = 0;
    endtask

    task automatic t_poll();
        int m0;
        put_desc(32'h80, 32'h0, 32'h0, 32'h0, 16'd0, 8'h00);
        ctl_poll_en = 1; ctl_poll_gap = 8'd10;
        m0 = mv_cnt;
        load_ptr(32'h80);
        pulse_go();
        repeat (60) @(negedge clk);
        check("R8 still busy", {31'b0, busy}, 1);
        check("R8 poll spacing", t_last - t_prev, 13);
        check("R8 no mover", mv_cnt, m0);
        load_ptr(32'h1234);
        check("R13 ptr ignored", nxt_ptr, 32'h80);
        put_desc(32'h80, 32'h5100, 32'h5200, 32'h40, 16'd8, 8'h81);
        begin
            int n = 0;
            while (mv_cnt == m0 && n < 500) begin @(negedge clk); n++; end
        end
        ctl_poll_en = 0;
        wait_idle("R8 idle");
        check("R8 picked up", mv_cnt, m0 + 1);
        check("R8 R6 nxt_ptr", nxt_ptr, 32'h40);
        check("R8 wb", mem[39], {8'h01, 8'h80, 16'd8});
    endtask

    task automatic t_halt();
        int m0, c0;
        put_desc(32'hA0, 32'h8000, 32'h8100, 32'hC0, 16'd4, 8'h81);
        put_desc(32'hC0, 32'h9000, 32'h9100, 32'h40, 16'd6, 8'h81);
        ctl_halt_on_err = 1; mv_stat_cfg = 8'h01;
        m0 = mv_cnt; c0 = chain_cnt;
        load_ptr(32'hA0);
        pulse_go();
        wait_idle("R9 idle");
        check("R9 one descriptor", mv_cnt, m0 + 1);
        check("R9 nxt_ptr", nxt_ptr, 32'hC0);
        check("R9 no chain_done", chain_cnt, c0);
        check("R9 next untouched", mem[55], {8'h81, 24'h0});
        check("R9 wb", mem[47], {8'h01, 8'h01, 16'd4});
        ctl_halt_on_err = 0; mv_stat_cfg = 8'h80;
    endtask

    task automatic t_soft();
        int m0, w0;
        mv_delay = 20;
        m0 = mv_cnt; w0 = wr_cnt;
        pulse_go();
        begin
            int n = 0;
            while (mv_cnt == m0 && n < 500) begin @(negedge clk); n++; end
        end
        @(negedge clk); ctl_soft_rst = 1;
        @(negedge clk); ctl_soft_rst = 0;
        check("R10 idle", {31'b0, busy}, 0);
        repeat (40) @(negedge clk);
        check("R10 no write", wr_cnt, w0);
        check("R10 owned kept", mem[55], {8'h81, 24'h0});
        check("R10 nxt_ptr", nxt_ptr, 32'hC0);
        mv_delay = 3;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_chain();
        t_keep_own();
        t_poll();
        t_halt();
        t_soft();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule